// File: doc/BRIEF.md
# Slot-Rotated Interrupt Level Router

This block gathers level-sensitive interrupt requests from up to 64 expansion-bus functions and folds them onto four shared request lines. Each function reports a change on one of its four interrupt pins through an event port that carries a storage index (which function), the function's 8-bit bus address (device number in bits 7:3, function number in bits 2:0), the pin and the new level. The pin is rotated by the device number before it is stored, so functions in neighbouring slots that all use their first pin spread across different shared lines.

Each shared line is high while any stored bit on it is high. A programmable 8-bit steering register per shared line chooses which of the legacy controller inputs that line drives. The steering registers sit at four consecutive byte addresses on a small write port and come out of reset disabled. Several shared lines may be steered to the same legacy input; that input is then the OR of all of them. The legacy outputs are registered.

Top module: `irq_slot_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every bit of `irq_out` is 0.
- R2: An event with pin P (0 to 3) from a function whose bus address has device number D (address bits 7:3) lands on shared line (P + D) mod 4; the function number (address bits 2:0) has no effect on the line chosen.
- R3: An event overwrites only the one stored bit selected by its storage index and its rotated line; the bits of other functions on that line and of the same function on other lines keep their values.
- R4: A shared line is active exactly when at least one of its stored bits is 1; when no line is active every output is 0.
- R5: A write to byte address 0x60 + L (L = 0 to 3, line 0 to 3) loads the steering register of shared line L; every steering register resets to 0x80, so no line reaches an output until it is programmed.
- R6: A steering register drives output bit V only when its bit 7 is 0 and its low seven bits hold a value V from 0 to 15; bit 7 set, or a value of 16 or more, steers the line nowhere.
- R7: Each output bit is the OR of all active, enabled shared lines steered to it, so two lines sharing one output keep it high while either is active.
- R8: Writes to addresses outside 0x60 to 0x63 change no steering register.
- R9: An event or steering write taken at clock edge N is visible on `irq_out` after edge N+1 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Level-change event strobe |
| evt_dev | input | 6 | Storage index of the reporting function |
| evt_devfn | input | 8 | Bus address of the function: device 7:3, function 2:0 |
| evt_pin | input | 2 | Interrupt pin, 0 = first pin to 3 = fourth pin |
| evt_level | input | 1 | New level of that pin |
| cfg_we | input | 1 | Steering register write strobe |
| cfg_addr | input | 8 | Byte address of the write |
| cfg_wdata | input | 8 | Write data |
| irq_out | output | 16 | One level per legacy interrupt input |

## Verification
The hardest situation to reach is a shared output held by two sources at once, either two functions on one rotated line or two lines steered to one output, and then released one source at a time. The stimulus reaches it by picking device numbers whose rotation collides (device 2 and device 6, both on line 2 with the first pin) and by programming the steering registers to the paired pattern 11, 9, 11, 9, then clearing sources one by one while the reference model tracks every stored bit. A full sweep over all 32 device numbers and four pins, with varied function numbers, covers the rotation arithmetic.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int NUM_LINES = 4;
    localparam int LINE_W    = 2;
    localparam int ROUTE_W   = 8;
    localparam int SLOT_LSB  = 3;   // device number starts here in the bus address
    localparam int ADDR_W    = 8;

    typedef logic [ROUTE_W-1:0] route_t;
    typedef logic [LINE_W-1:0]  line_idx_t;

    localparam route_t ROUTE_RESET = 8'h80;
endpackage

// File: rtl/irq_level_store.sv
module irq_level_store
    import irq_router_pkg::*;
#(
    parameter  int NUM_DEV = 64,
    localparam int DEV_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_valid,
    input  logic [DEV_W-1:0]     upd_dev,
    input  line_idx_t            upd_line,
    input  logic                 upd_level,
    output logic [NUM_LINES-1:0] line_active
);
    typedef struct packed {
        logic [NUM_LINES-1:0][NUM_DEV-1:0] bits;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_valid) begin
            st_d.bits[upd_line][upd_dev] = upd_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_line_or
        assign line_active[j] = |st_q.bits[j];
    end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
    import irq_router_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  route_t                 cfg_wdata,
    output route_t [NUM_LINES-1:0] route_q
);
    typedef struct packed {
        route_t [NUM_LINES-1:0] regs;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  hit;

    assign hit = (cfg_addr[ADDR_W-1:LINE_W] == ROUTE_BASE[ADDR_W-1:LINE_W]);

    always_comb begin
        rg_d = rg_q;
        if (cfg_we && hit) begin
            rg_d.regs[cfg_addr[LINE_W-1:0]] = cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.regs <= {NUM_LINES{ROUTE_RESET}};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign route_q = rg_q.regs;
endmodule

// File: rtl/irq_steer.sv
module irq_steer
    import irq_router_pkg::*;
#(
    parameter  int NUM_IRQ = 16,
    localparam int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
    input  logic [NUM_LINES-1:0]   line_active,
    input  route_t [NUM_LINES-1:0] route,
    output logic [NUM_IRQ-1:0]     irq_next
);
    logic [NUM_LINES-1:0] line_en;

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_en
        assign line_en[j] = !route[j][ROUTE_W-1] &&
                            ({1'b0, route[j][ROUTE_W-2:0]} < ROUTE_W'(NUM_IRQ));
    end

    always_comb begin
        irq_next = '0;
        for (int j = 0; j < NUM_LINES; j++) begin
            if (line_active[j] && line_en[j]) begin
                irq_next[route[j][IDX_W-1:0]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_slot_router.sv
module irq_slot_router
    import irq_router_pkg::*;
#(
    parameter  int                NUM_DEV    = 64,
    parameter  int                NUM_IRQ    = 16,
    parameter  logic [ADDR_W-1:0] ROUTE_BASE = 8'h60,
    localparam int                DEV_W      = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [DEV_W-1:0]   evt_dev,
    input  logic [ADDR_W-1:0]  evt_devfn,
    input  logic [LINE_W-1:0]  evt_pin,
    input  logic               evt_level,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [ROUTE_W-1:0] cfg_wdata,
    output logic [NUM_IRQ-1:0] irq_out
);
    typedef struct packed {
        logic [NUM_IRQ-1:0] irq;
    } out_t;

    line_idx_t              evt_line;
    logic [NUM_LINES-1:0]   line_active;
    route_t [NUM_LINES-1:0] route_q;
    logic [NUM_IRQ-1:0]     irq_next;
    out_t                   out_d, out_q;

    // rotate the pin by the low bits of the device number (mod 4)
    assign evt_line = evt_pin + evt_devfn[SLOT_LSB+LINE_W-1:SLOT_LSB];

    irq_level_store #(.NUM_DEV(NUM_DEV)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_valid   (evt_valid),
        .upd_dev     (evt_dev),
        .upd_line    (evt_line),
        .upd_level   (evt_level),
        .line_active (line_active)
    );

    irq_route_regs #(.ROUTE_BASE(ROUTE_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .route_q   (route_q)
    );

    irq_steer #(.NUM_IRQ(NUM_IRQ)) u_steer (
        .line_active (line_active),
        .route       (route_q),
        .irq_next    (irq_next)
    );

    always_comb begin
        out_d     = out_q;
        out_d.irq = irq_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_out = out_q.irq;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int                NUM_IRQ    = 16,
    parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   evt_valid,
    input logic [ADDR_W-1:0]      evt_devfn,
    input logic [LINE_W-1:0]      evt_pin,
    input logic                   evt_level,
    input logic                   cfg_we,
    input logic [ADDR_W-1:0]      cfg_addr,
    input logic [ROUTE_W-1:0]     cfg_wdata,
    input route_t [NUM_LINES-1:0] route_q,
    input logic [NUM_LINES-1:0]   line_active,
    input logic [NUM_IRQ-1:0]     irq_out
);
    logic               live;
    logic [NUM_IRQ-1:0] en_mask;
    logic               in_window;
    line_idx_t          exp_line;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    always_comb begin
        en_mask = '0;
        for (int j = 0; j < NUM_LINES; j++) begin
            for (int k = 0; k < NUM_IRQ; k++) begin
                if (route_q[j] == ROUTE_W'(k)) en_mask[k] = 1'b1;
            end
        end
    end

    assign in_window = (cfg_addr >= ROUTE_BASE) && (cfg_addr < ROUTE_BASE + ADDR_W'(NUM_LINES));
    assign exp_line  = line_idx_t'((32'(evt_pin) + 32'(evt_devfn[7:3])) % 4);

    // R6
    out_enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ((irq_out & ~$past(en_mask)) == '0));

    // R4
    idle_lines_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_active == '0) |=> (irq_out == '0));

    // R5
    route_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && in_window) |=> (route_q[$past(cfg_addr[LINE_W-1:0])] == $past(cfg_wdata)));

    // R8
    route_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we || !in_window) |=> $stable(route_q));

    // R2
    level_set_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_level) |=> line_active[$past(exp_line)]);
endmodule

bind irq_slot_router irq_router_chk #(.NUM_IRQ(NUM_IRQ), .ROUTE_BASE(ROUTE_BASE)) u_chk (.*);

// File: tb/test_irq_slot_router.sv
module test_irq_slot_router;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_valid;
    logic [5:0]  evt_dev;
    logic [7:0]  evt_devfn;
    logic [1:0]  evt_pin;
    logic        evt_level;
    logic        cfg_we;
    logic [7:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_lvl   [4];
    logic [7:0]  m_route [4];

    irq_slot_router i_irq_slot_router (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dev(evt_dev),
        .evt_devfn(evt_devfn), .evt_pin(evt_pin), .evt_level(evt_level),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [15:0] model_out();
        logic [15:0] r = '0;
        for (int j = 0; j < 4; j++) begin
            if (m_lvl[j] != 0 && !m_route[j][7] && m_route[j][6:0] < 16)
                r[m_route[j][3:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic check_val(string rq, logic [15:0] exp);
        checks++;
        if (irq_out !== exp) begin
            errors++;
            $display("FAIL %s irq_out got %h expected %h", rq, irq_out, exp);
        end
    endtask

    // drive one event across one clock edge, return at the following negedge
    task automatic post(int dev, int slot, int fn, int pin, bit lvl);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_dev   = 6'(dev);
        evt_devfn = {5'(slot), 3'(fn)};
        evt_pin   = 2'(pin);
        evt_level = lvl;
        m_lvl[(pin + slot) % 4][dev] = lvl;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic wr(int addr, int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = 8'(addr);
        cfg_wdata = 8'(data);
        if (addr >= 8'h60 && addr <= 8'h63) m_route[addr - 8'h60] = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one more edge for the registered output, then compare with the model
    task automatic settle_check(string rq);
        @(negedge clk);
        check_val(rq, model_out());
    endtask

    initial begin
        logic [15:0] prev;
        for (int j = 0; j < 4; j++) begin
            m_lvl[j]   = '0;
            m_route[j] = 8'h80;
        end
        rst_n = 1'b0; evt_valid = 0; evt_dev = 0; evt_devfn = 0; evt_pin = 0;
        evt_level = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        repeat (3) @(negedge clk);
        check_val("R1 in reset", 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 after reset", 16'h0);

        // R5: reset steering is disabled
        post(0, 0, 0, 0, 1'b1);
        settle_check("R5 reset route 0x80");
        check_val("R5 reset route gives nothing", 16'h0);
        post(0, 0, 0, 0, 1'b0);
        settle_check("R5");

        wr(8'h60, 3); wr(8'h61, 4); wr(8'h62, 5); wr(8'h63, 6);
        settle_check("R5 program");

        // R2: every device number and pin, function number varied
        for (int s = 0; s < 32; s++) begin
            for (int p = 0; p < 4; p++) begin
                post(s, s, (s + p) % 8, p, 1'b1);
                settle_check("R2 rotate set");
                post(s, s, (s + p) % 8, p, 1'b0);
                settle_check("R2 rotate clear");
            end
        end

        // R9: not visible after edge N, visible after N+1
        prev = model_out();
        post(1, 1, 0, 0, 1'b1);
        check_val("R9 before N+1", prev);
        settle_check("R9 after N+1");
        post(1, 1, 0, 0, 1'b0);
        settle_check("R9");

        // R3 / R4: devices 63 and 10 collide on line 2
        post(63, 2, 0, 0, 1'b1);
        post(10, 6, 3, 0, 1'b1);
        settle_check("R4 two sources");
        post(63, 2, 0, 0, 1'b0);
        settle_check("R3 other device kept");
        check_val("R3 line 2 still high", 16'h0020);
        post(10, 6, 3, 0, 1'b0);
        settle_check("R4 all clear");
        check_val("R4 all clear value", 16'h0);
        post(5, 0, 0, 0, 1'b1);
        post(5, 0, 0, 1, 1'b1);
        settle_check("R3 same device two lines");
        post(5, 0, 0, 0, 1'b0);
        settle_check("R3 other line kept");
        check_val("R3 line 1 only", 16'h0010);
        post(5, 0, 0, 1, 1'b0);

        // R7: paired steering 11,9,11,9
        wr(8'h60, 11); wr(8'h61, 9); wr(8'h62, 11); wr(8'h63, 9);
        post(20, 0, 0, 0, 1'b1);
        post(21, 0, 0, 2, 1'b1);
        settle_check("R7 merged A,C");
        check_val("R7 bit 11", 16'h0800);
        post(20, 0, 0, 0, 1'b0);
        settle_check("R7 one source left");
        check_val("R7 bit 11 held", 16'h0800);
        post(22, 1, 0, 0, 1'b1);
        settle_check("R7 bits 9 and 11");
        post(21, 0, 0, 2, 1'b0);
        post(22, 1, 0, 0, 1'b0);
        settle_check("R7 cleared");

        // R6: disable bit and out-of-range values
        post(30, 0, 0, 0, 1'b1);
        wr(8'h60, 8'h8B);
        settle_check("R6 bit7 set");
        check_val("R6 bit7 value", 16'h0);
        wr(8'h60, 8'h10);
        settle_check("R6 value 16");
        wr(8'h60, 8'h7F);
        settle_check("R6 value 127");
        wr(8'h60, 8'h0F);
        settle_check("R6 value 15");
        check_val("R6 bit 15", 16'h8000);
        wr(8'h60, 8'h00);
        settle_check("R6 value 0");

        // R8: writes outside the window
        wr(8'h60, 3);
        settle_check("R8 baseline");
        wr(8'h64, 8'h05);
        settle_check("R8 addr 0x64");
        wr(8'h5F, 8'h05);
        settle_check("R8 addr 0x5F");
        wr(8'hE0, 8'h05);
        settle_check("R8 addr 0xE0");
        check_val("R8 still bit 3", 16'h0008);
        post(30, 0, 0, 0, 1'b0);
        settle_check("R8 cleared");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule